// File: doc/BRIEF.md
# Fault Escalation Controller

This block decides how an exception is delivered when a new fault turns up while an earlier exception is still being delivered. An entry sequencer presents fault requests, each with a vector number. It also presents non-maskable interrupt requests and a pulse that marks the end of the current delivery. The controller answers one cycle later with the vector to deliver and the stack slot to deliver it on. Slot 0 means the current kernel stack; the other slots are dedicated emergency stacks.

Escalation has three levels. A fault taken with nothing in flight is delivered as an ordinary exception. A fault during an ordinary delivery is turned into a double fault, which is always delivered on a dedicated emergency stack. A fault during double-fault delivery cannot be recovered and becomes a core reset request. A non-maskable interrupt is never escalated: it takes priority over a fault in the same cycle and is delivered on its own emergency stack. A fault that arrives in the same cycle as the end of delivery counts as a fresh, re-entrant fault.

Top module: `fault_escalator`

## Requirements
- R1: After reset `dlv_valid` and `core_rst` are 0 and the controller is idle, so the first fault is delivered as an ordinary fault.
- R2: A fault (`flt_req`=1) while idle, with `nmi_req`=0, gives `dlv_valid`=1 in the next cycle with `dlv_vector` equal to `flt_vector` and `dlv_stack`=0, and the controller enters ordinary delivery.
- R3: A fault during ordinary delivery, with `deliv_done`=0 and `nmi_req`=0, gives `dlv_valid`=1 in the next cycle with `dlv_vector`=8 (DF_VEC) and `dlv_stack`=1 (DF_SLOT), and the controller enters double-fault delivery.
- R4: A fault during double-fault delivery, with `deliv_done`=0 and `nmi_req`=0, gives `core_rst`=1 in the next cycle with `dlv_valid`=0.
- R5: `nmi_req`=1 in any state other than reset has priority over a fault in the same cycle. In the next cycle it gives `dlv_vector`=2 (NMI_VEC) and `dlv_stack`=2 (NMI_SLOT). It never raises the escalation level: a later fault during double-fault delivery still causes a reset, and a fault after an NMI that started from idle becomes a double fault.
- R6: `deliv_done`=1 returns either delivery state to idle. A fault in the same cycle as `deliv_done` is delivered as an ordinary fault (its own vector, slot 0).
- R7: `core_rst` lasts exactly one cycle. All inputs during that cycle are ignored (no delivery in the following cycle), and the controller is idle after it.
- R8: `dlv_valid` is high for exactly one cycle per accepted request and is 0 in the cycle after a cycle with no fault and no NMI request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_req | input | 1 | Fault request |
| flt_vector | input | VEC_W | Vector of the requested fault |
| nmi_req | input | 1 | Non-maskable interrupt request |
| deliv_done | input | 1 | Current delivery has finished |
| dlv_valid | output | 1 | Delivery command valid |
| dlv_vector | output | VEC_W | Vector to deliver |
| dlv_stack | output | SLOT_W | Stack slot, 0 = current kernel stack |
| core_rst | output | 1 | One-cycle core reset request |

## Verification
The bench targets three corner cases. The first is a fault landing in the same cycle as `deliv_done`; a design that gave the end of delivery too little priority would wrongly turn this into a double fault. The second is an NMI arriving together with a fault during double-fault delivery; a design that let the NMI reset the escalation level would fail to reset on the next fault. The third is the cycle that carries the reset request; a design that did not ignore inputs there would start a delivery, and one that held the reset too long would show `core_rst` for two cycles. Random mixes of requests, NMIs and completions are checked against a bench model of the escalation rules.

// File: rtl/fault_escalator.sv
module fault_escalator #(
  parameter int VEC_W    = 8,
  parameter int SLOT_W   = 3,
  parameter int DF_VEC   = 8,
  parameter int NMI_VEC  = 2,
  parameter int DF_SLOT  = 1,
  parameter int NMI_SLOT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_req,
  input  logic [VEC_W-1:0]  flt_vector,
  input  logic              nmi_req,
  input  logic              deliv_done,
  output logic              dlv_valid,
  output logic [VEC_W-1:0]  dlv_vector,
  output logic [SLOT_W-1:0] dlv_stack,
  output logic              core_rst
);

  typedef enum logic [1:0] {S_IDLE, S_DELIV, S_DF, S_RST} st_t;

  st_t st_q, st_d;
  logic              v_d;
  logic [VEC_W-1:0]  vec_d;
  logic [SLOT_W-1:0] slot_d;

  always_comb begin
    st_d   = st_q;
    v_d    = 1'b0;
    vec_d  = flt_vector;
    slot_d = '0;
    if (st_q == S_RST) begin
      st_d = S_IDLE;
    end else if (nmi_req) begin
      v_d    = 1'b1;
      vec_d  = VEC_W'(NMI_VEC);
      slot_d = SLOT_W'(NMI_SLOT);
      st_d   = (st_q == S_DF && !deliv_done) ? S_DF : S_DELIV;
    end else if (flt_req) begin
      if (st_q == S_IDLE || deliv_done) begin
        v_d  = 1'b1;
        st_d = S_DELIV;
      end else if (st_q == S_DELIV) begin
        v_d    = 1'b1;
        vec_d  = VEC_W'(DF_VEC);
        slot_d = SLOT_W'(DF_SLOT);
        st_d   = S_DF;
      end else begin
        st_d = S_RST;
      end
    end else if (deliv_done) begin
      st_d = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      dlv_valid  <= 1'b0;
      dlv_vector <= '0;
      dlv_stack  <= '0;
    end else begin
      st_q       <= st_d;
      dlv_valid  <= v_d;
      dlv_vector <= vec_d;
      dlv_stack  <= slot_d;
    end
  end

  assign core_rst = (st_q == S_RST);

  p_double_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DELIV && flt_req && !nmi_req && !deliv_done)
    |=> (dlv_valid && dlv_vector == VEC_W'(DF_VEC) && dlv_stack == SLOT_W'(DF_SLOT)));

  p_triple_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DF && flt_req && !nmi_req && !deliv_done) |=> (core_rst && !dlv_valid));

  p_nmi_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !core_rst) |=> (dlv_valid && dlv_stack == SLOT_W'(NMI_SLOT)));

  p_reentrant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_req && deliv_done && !nmi_req && !core_rst) |=> (dlv_valid && dlv_stack == '0));

  p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> (!core_rst && !dlv_valid));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_req && !nmi_req) |=> !dlv_valid);

endmodule

// File: tb/sim_fault_escalator.sv
module sim_fault_escalator;
  localparam int VW = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flt_req = 1'b0, nmi_req = 1'b0, deliv_done = 1'b0;
  logic [VW-1:0] flt_vector = '0;
  logic dlv_valid, core_rst;
  logic [VW-1:0] dlv_vector;
  logic [SW-1:0] dlv_stack;

  int checks = 0, fails = 0;
  int m_st = 0;
  logic e_v = 0, e_rst = 0;
  logic [VW-1:0] e_vec = '0;
  logic [SW-1:0] e_slot = '0;
  string e_tag = "R1";

  always #2.5 clk = ~clk;

  fault_escalator u0 (.clk(clk), .rst_n(rst_n), .flt_req(flt_req), .flt_vector(flt_vector),
    .nmi_req(nmi_req), .deliv_done(deliv_done), .dlv_valid(dlv_valid),
    .dlv_vector(dlv_vector), .dlv_stack(dlv_stack), .core_rst(core_rst));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // model states: 0 idle, 1 delivering, 2 double fault, 3 reset
  task automatic model(logic f, logic [VW-1:0] vec, logic n, logic d);
    e_v = 0; e_vec = 'x; e_slot = 'x;
    e_rst = 0;
    if (m_st == 3) begin
      m_st = 0; e_tag = "R7";
    end else if (n) begin
      e_v = 1; e_vec = 2; e_slot = 2; e_tag = "R5";
      if (!(m_st == 2 && !d)) m_st = 1;
    end else if (f && (m_st == 0 || d)) begin
      e_v = 1; e_vec = vec; e_slot = 0;
      e_tag = (m_st == 0) ? "R2" : "R6";
      m_st = 1;
    end else if (f && m_st == 1) begin
      e_v = 1; e_vec = 8; e_slot = 1; e_tag = "R3"; m_st = 2;
    end else if (f) begin
      e_rst = 1; e_tag = "R4"; m_st = 3;
    end else begin
      e_tag = "R8";
      if (d) m_st = 0;
    end
  endtask

  task automatic step(logic f, logic [VW-1:0] vec, logic n, logic d);
    flt_req = f; flt_vector = vec; nmi_req = n; deliv_done = d;
    model(f, vec, n, d);
    @(negedge clk);
    chk(e_tag, 16'(dlv_valid), 16'(e_v));
    chk(e_tag, 16'(core_rst), 16'(e_rst));
    if (e_v) begin
      chk(e_tag, 16'(dlv_vector), 16'(e_vec));
      chk(e_tag, 16'(dlv_stack), 16'(e_slot));
    end
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1", 16'(dlv_valid), 16'h0);
    chk("R1", 16'(core_rst), 16'h0);
    rst_n = 1'b1;
    // R2 ordinary, R3 double, R4 reset, R7 ignore during reset
    step(1, 8'h0e, 0, 0);
    step(1, 8'h0d, 0, 0);
    step(1, 8'h0e, 0, 0);
    step(1, 8'h0e, 1, 0);
    step(1, 8'h21, 0, 0);   // R7: controller idle again, ordinary fault
    // R6: fault with done is re-entrant
    step(1, 8'h0e, 0, 1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    // R5: NMI in double-fault delivery keeps the level
    step(1, 8'h0e, 0, 0);
    step(1, 8'h0e, 0, 0);
    step(1, 8'h0e, 1, 0);
    step(1, 8'h0e, 0, 0);
    step(0, 0, 0, 0);
    // R5: NMI from idle, then fault escalates to double
    step(0, 0, 1, 0);
    step(1, 8'h33, 0, 0);
    step(0, 0, 0, 1);
    for (int i = 0; i < 3000; i++) begin
      logic f, n, d;
      f = ($urandom % 100) < 45;
      n = ($urandom % 100) < 8;
      d = ($urandom % 100) < 30;
      step(f, VW'($urandom), n, d);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule